// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the software-visible register bank of a simple colour LCD controller. A 32-bit bus reaches it through a 4 KB byte-addressed window in which each register occupies one word. It holds four panel timing words, the upper and lower frame base addresses, a control word, an interrupt mask and the frame status. From two of the timing words it derives the active panel size in pixels. It also presents the enable state and the colour-depth code to the pixel engine, which lies outside this block.

A one-cycle frame pulse from the display timing marks each frame. It sets two status flags, but only while the controller is both enabled and powered. Software acknowledges a flag by writing a one to its bit in the clear register. A single level interrupt line is high while any unmasked flag is set. A two-bit variant input selects one of three register layouts. In the base layout the mask sits below the control word. The other two layouts swap those two. The extended layout also reports different identification bytes.

Top module: `lcd_regs_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `panel_on` is low.
- R2: Word offsets 0, 1, 2 and 3 (timing words) and 4 and 5 (upper and lower base) store the full 32-bit value written and read it back.
- R3: With `variant` = 0 the interrupt mask is at word offset 6 and the control word at 7. With any other `variant` the two swap places, for both reads and writes.
- R4: `panel_on` is high only when control bit 0 (enable) and control bit 11 (power) are both set. `bpp_code` equals control bits [3:1].
- R5: `active_width` = ((timing0 & 0xFC) + 4) * 4 and `active_height` = (timing1 & 0x3FF) + 1.
- R6: A `frame_tick` pulse while `panel_on` is high sets raw status bit 2 (next base) and bit 3 (vertical compare). A pulse while `panel_on` is low changes nothing.
- R7: A write to word offset 10 clears every raw status bit whose written bit is 1 and leaves the others. If an enabled tick lands in the same cycle, the set wins.
- R8: Word offset 8 reads raw status and word offset 9 reads raw status AND mask. `irq` is high exactly when that masked value is non-zero, from the cycle after the write or tick that changed it.
- R9: Word offsets 11 and 12 read back the upper and lower base.
- R10: Byte offsets 0xFE0 to 0xFFC each return one identification byte, indexed by (offset - 0xFE0) >> 2. The sequence is 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. With `variant` = 2 the bytes at index 0 and index 2 become 0x11 and 0x24.
- R11: Undefined offsets, and palette-range offsets, read 0. Writes to them and to the read-only offsets 8, 9, 11, 12 and the identification range change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant | input | 2 | Layout select: 0 base, 1 swapped, 2 extended, 3 treated as swapped |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high with `bus_sel` |
| bus_addr | input | 12 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_tick | input | 1 | One-cycle frame pulse |
| irq | output | 1 | Level interrupt |
| panel_on | output | 1 | Enabled and powered |
| bpp_code | output | 3 | Colour depth code |
| active_width | output | 11 | Panel width in pixels |
| active_height | output | 11 | Panel height in lines |

## Verification
The properties assume that `frame_tick` is a single-cycle pulse sampled on the clock. They also assume that a clear write is one bus cycle, with `bus_sel`, `bus_wr`, address and data all stable across the edge. The stimulus drives every input at the falling edge and holds it for exactly one full cycle, so each write and each tick is seen at exactly one rising edge. `variant` is treated as static strap data. The stimulus changes it only between accesses, never while a write or tick is in flight, so no property sees the layout move under a pending write.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;
  typedef enum logic [1:0] {
    VAR_BASE = 2'd0,
    VAR_SWAP = 2'd1,
    VAR_EXT  = 2'd2,
    VAR_ALT  = 2'd3
  } variant_e;

  localparam int OFF_TIM0   = 0;
  localparam int OFF_UPBASE = 4;
  localparam int OFF_LPBASE = 5;
  localparam int OFF_LOW    = 6;
  localparam int OFF_HIGH   = 7;
  localparam int OFF_RAW    = 8;
  localparam int OFF_MASKED = 9;
  localparam int OFF_CLEAR  = 10;
  localparam int OFF_UPCUR  = 11;
  localparam int OFF_LPCUR  = 12;

  localparam int CTL_ENABLE = 0;
  localparam int CTL_POWER  = 11;
  localparam int STAT_LSB   = 2;
  localparam int STAT_W     = 2;

  function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic ext);
    logic [7:0] b;
    case (idx)
      3'd0: b = ext ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = ext ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcd_ctrl_bank.sv
module lcd_ctrl_bank
  import lcd_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 10,
  parameter int N_TIM  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [OFF_W-1:0]              word_off,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          swap,
  output logic [N_TIM-1:0][DATA_W-1:0]  tim_q,
  output logic [DATA_W-1:0]             upbase_q,
  output logic [DATA_W-1:0]             lpbase_q,
  output logic [DATA_W-1:0]             ctrl_q,
  output logic [DATA_W-1:0]             mask_q
);
  logic [OFF_W-1:0] mask_off, ctrl_off;
  logic             up_we, lp_we, mask_we, ctrl_we;

  always_comb begin
    mask_off = swap ? OFF_W'(OFF_HIGH) : OFF_W'(OFF_LOW);
    ctrl_off = swap ? OFF_W'(OFF_LOW)  : OFF_W'(OFF_HIGH);
    up_we    = wr_en && (word_off == OFF_W'(OFF_UPBASE));
    lp_we    = wr_en && (word_off == OFF_W'(OFF_LPBASE));
    mask_we  = wr_en && (word_off == mask_off);
    ctrl_we  = wr_en && (word_off == ctrl_off);
  end

  for (genvar i = 0; i < N_TIM; i++) begin : g_tim
    logic tim_we;
    logic [DATA_W-1:0] tim_d;
    always_comb begin
      tim_we = wr_en && (word_off == OFF_W'(OFF_TIM0 + i));
      tim_d  = tim_we ? wdata : tim_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim_q[i] <= '0;
      else        tim_q[i] <= tim_d;
    end
  end

  logic [DATA_W-1:0] up_d, lp_d, mask_d, ctrl_d;
  always_comb begin
    up_d   = up_we   ? wdata : upbase_q;
    lp_d   = lp_we   ? wdata : lpbase_q;
    mask_d = mask_we ? wdata : mask_q;
    ctrl_d = ctrl_we ? wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upbase_q <= '0;
      lpbase_q <= '0;
      mask_q   <= '0;
      ctrl_q   <= '0;
    end else begin
      upbase_q <= up_d;
      lpbase_q <= lp_d;
      mask_q   <= mask_d;
      ctrl_q   <= ctrl_d;
    end
  end
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit #(
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_on,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic [STAT_W-1:0] mask_bits,
  output logic [STAT_W-1:0] raw_q,
  output logic              irq
);
  logic [STAT_W-1:0] raw_d, clr_eff;

  always_comb begin
    clr_eff = clr_we ? clr_bits : '0;
    raw_d   = (raw_q & ~clr_eff) | (tick_on ? {STAT_W{1'b1}} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign irq = |(raw_q & mask_bits);
endmodule

// File: rtl/lcd_size_calc.sv
module lcd_size_calc #(
  parameter int DIM_W = 11
) (
  input  logic [5:0]       col_field,
  input  logic [9:0]       row_field,
  output logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] height
);
  always_comb begin
    width  = DIM_W'({5'd0, col_field} + 11'd1) << 4;
    height = DIM_W'({1'b0, row_field} + 11'd1);
  end
endmodule

// File: rtl/lcd_read_mux.sv
module lcd_read_mux
  import lcd_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 10,
  parameter int N_TIM  = 4
) (
  input  logic [OFF_W-1:0]             word_off,
  input  logic                         swap,
  input  logic                         ext,
  input  logic [N_TIM-1:0][DATA_W-1:0] tim_q,
  input  logic [DATA_W-1:0]            upbase_q,
  input  logic [DATA_W-1:0]            lpbase_q,
  input  logic [DATA_W-1:0]            ctrl_q,
  input  logic [DATA_W-1:0]            mask_q,
  input  logic [DATA_W-1:0]            raw_word,
  output logic [DATA_W-1:0]            rdata
);
  logic id_hit;
  assign id_hit = &word_off[OFF_W-1:3];

  always_comb begin
    rdata = '0;
    if (id_hit) begin
      rdata = DATA_W'(id_byte(word_off[2:0], ext));
    end else if (word_off < OFF_W'(N_TIM)) begin
      rdata = tim_q[word_off[$clog2(N_TIM)-1:0]];
    end else begin
      case (word_off)
        OFF_W'(OFF_UPBASE), OFF_W'(OFF_UPCUR): rdata = upbase_q;
        OFF_W'(OFF_LPBASE), OFF_W'(OFF_LPCUR): rdata = lpbase_q;
        OFF_W'(OFF_LOW):    rdata = swap ? ctrl_q : mask_q;
        OFF_W'(OFF_HIGH):   rdata = swap ? mask_q : ctrl_q;
        OFF_W'(OFF_RAW):    rdata = raw_word;
        OFF_W'(OFF_MASKED): rdata = raw_word & mask_q;
        default:            rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lcd_regs_top.sv
module lcd_regs_top
  import lcd_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DIM_W  = 11,
  localparam int OFF_W = ADDR_W - 2,
  localparam int N_TIM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        variant,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_tick,
  output logic              irq,
  output logic              panel_on,
  output logic [2:0]        bpp_code,
  output logic [DIM_W-1:0]  active_width,
  output logic [DIM_W-1:0]  active_height
);
  logic [OFF_W-1:0]             word_off;
  logic                         wr_en, swap, ext, clr_we, tick_on;
  logic [N_TIM-1:0][DATA_W-1:0] tim_q;
  logic [DATA_W-1:0]            upbase_q, lpbase_q, ctrl_q, mask_q, raw_word;
  logic [STAT_W-1:0]            raw_q, mask_stat, clr_bits;

  always_comb begin
    word_off  = bus_addr[ADDR_W-1:2];
    wr_en     = bus_sel && bus_wr;
    swap      = variant_e'(variant) != VAR_BASE;
    ext       = variant_e'(variant) == VAR_EXT;
    clr_we    = wr_en && (word_off == OFF_W'(OFF_CLEAR));
    clr_bits  = bus_wdata[STAT_LSB +: STAT_W];
    mask_stat = mask_q[STAT_LSB +: STAT_W];
    panel_on  = ctrl_q[CTL_ENABLE] && ctrl_q[CTL_POWER];
    bpp_code  = ctrl_q[3:1];
    tick_on   = frame_tick && panel_on;
    raw_word  = '0;
    raw_word[STAT_LSB +: STAT_W] = raw_q;
  end

  lcd_ctrl_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W), .N_TIM(N_TIM)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word_off(word_off),
    .wdata(bus_wdata), .swap(swap), .tim_q(tim_q), .upbase_q(upbase_q),
    .lpbase_q(lpbase_q), .ctrl_q(ctrl_q), .mask_q(mask_q)
  );

  lcd_irq_unit #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .tick_on(tick_on), .clr_we(clr_we),
    .clr_bits(clr_bits), .mask_bits(mask_stat), .raw_q(raw_q), .irq(irq)
  );

  lcd_size_calc #(.DIM_W(DIM_W)) u_size (
    .col_field(tim_q[0][7:2]), .row_field(tim_q[1][9:0]),
    .width(active_width), .height(active_height)
  );

  lcd_read_mux #(.DATA_W(DATA_W), .OFF_W(OFF_W), .N_TIM(N_TIM)) u_rmux (
    .word_off(word_off), .swap(swap), .ext(ext), .tim_q(tim_q),
    .upbase_q(upbase_q), .lpbase_q(lpbase_q), .ctrl_q(ctrl_q),
    .mask_q(mask_q), .raw_word(raw_word), .rdata(bus_rdata)
  );
endmodule

// File: rtl/lcd_regs_chk.sv
module lcd_regs_chk #(
  parameter int STAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              panel_on,
  input logic              clr_we,
  input logic [STAT_W-1:0] clr_bits,
  input logic [STAT_W-1:0] raw_q,
  input logic [STAT_W-1:0] mask_stat,
  input logic              irq,
  input logic [3:0]        width_lsbs
);
  assert_tick_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && panel_on) |=> (raw_q == {STAT_W{1'b1}}));

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !(frame_tick && panel_on)) |=> ((raw_q & $past(clr_bits)) == '0));

  assert_status_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !(frame_tick && panel_on)) |=> $stable(raw_q));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_stat == '0) |-> !irq);

  assert_width_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    width_lsbs == 4'd0);
endmodule

bind lcd_regs_top lcd_regs_chk #(.STAT_W(2)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .panel_on(panel_on),
  .clr_we(clr_we), .clr_bits(clr_bits), .raw_q(raw_q), .mask_stat(mask_stat),
  .irq(irq), .width_lsbs(active_width[3:0])
);

// File: tb/test_lcd_regs_top.sv
module test_lcd_regs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, frame_tick = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, panel_on;
  logic [2:0]  bpp_code;
  logic [10:0] active_width, active_height;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lcd_regs_top i_lcd_regs_top (
    .clk(clk), .rst_n(rst_n), .variant(variant), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .frame_tick(frame_tick), .irq(irq),
    .panel_on(panel_on), .bpp_code(bpp_code), .active_width(active_width),
    .active_height(active_height)
  );

  typedef struct packed {
    logic        is_read;
    logic [9:0]  off;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'd0,  32'h1234_5678}, '{1'b1, 10'd0,  32'h1234_5678},
    '{1'b0, 10'd1,  32'h0000_013F}, '{1'b1, 10'd1,  32'h0000_013F},
    '{1'b0, 10'd2,  32'hA5A5_0001}, '{1'b1, 10'd2,  32'hA5A5_0001},
    '{1'b0, 10'd3,  32'h0000_FFFF}, '{1'b1, 10'd3,  32'h0000_FFFF},
    '{1'b0, 10'd4,  32'h8000_0000}, '{1'b1, 10'd4,  32'h8000_0000},
    '{1'b1, 10'd11, 32'h8000_0000},
    '{1'b0, 10'd5,  32'h8010_0000}, '{1'b1, 10'd5,  32'h8010_0000},
    '{1'b1, 10'd12, 32'h8010_0000},
    '{1'b0, 10'd6,  32'h0000_000C}, '{1'b1, 10'd6,  32'h0000_000C},
    '{1'b1, 10'd7,  32'h0000_0000},
    '{1'b0, 10'd8,  32'hFFFF_FFFF}, '{1'b1, 10'd8,  32'h0000_0000},
    '{1'b0, 10'd13, 32'h0000_0001}, '{1'b1, 10'd13, 32'h0000_0000},
    '{1'b1, 10'd32, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {off, 2'b00}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] ids [8];
    ids = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 panel_on", {31'd0, panel_on}, 32'd0);
    for (int i = 0; i < 13; i++) rd_chk("R1 reg", 12'(i * 4), 32'd0);
    check("R5 reset width", {21'd0, active_width}, 32'd16);
    check("R5 reset height", {21'd0, active_height}, 32'd1);

    // R2 R3 R9 R11 vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_read) begin
        @(negedge clk);
        rd_chk("R2/R3/R9/R11 table", {VECS[i].off, 2'b00}, VECS[i].data);
      end else begin
        wr(VECS[i].off, VECS[i].data);
      end
    end

    // R5 size derivation
    check("R5 width", {21'd0, active_width}, 32'd496);
    check("R5 height", {21'd0, active_height}, 32'd320);
    wr(10'd0, 32'h0000_00FF);
    wr(10'd1, 32'hFFFF_FC00);
    check("R5 max width", {21'd0, active_width}, 32'd1024);
    check("R5 min height", {21'd0, active_height}, 32'd1);

    // R6 R4: tick ignored unless enabled and powered
    tick();
    rd_chk("R6 tick off", 12'h020, 32'd0);
    wr(10'd7, 32'h0000_0001);
    check("R4 enable only", {31'd0, panel_on}, 32'd0);
    tick();
    rd_chk("R6 tick no power", 12'h020, 32'd0);
    wr(10'd7, 32'h0000_080B);
    check("R4 panel_on", {31'd0, panel_on}, 32'd1);
    check("R4 bpp", {29'd0, bpp_code}, 32'd5);
    rd_chk("R3 ctrl base", 12'h01C, 32'h0000_080B);
    tick();
    rd_chk("R6 raw after tick", 12'h020, 32'h0000_000C);
    rd_chk("R8 masked", 12'h024, 32'h0000_000C);
    check("R8 irq high", {31'd0, irq}, 32'd1);

    // R8 mask effect
    wr(10'd6, 32'h0000_0004);
    rd_chk("R8 masked part", 12'h024, 32'h0000_0004);
    check("R8 irq part", {31'd0, irq}, 32'd1);
    wr(10'd6, 32'h0000_0000);
    check("R8 irq masked off", {31'd0, irq}, 32'd0);
    rd_chk("R8 raw kept", 12'h020, 32'h0000_000C);

    // R7 clear
    wr(10'd10, 32'h0000_0008);
    rd_chk("R7 clear bit3", 12'h020, 32'h0000_0004);
    wr(10'd10, 32'hFFFF_FFFF);
    rd_chk("R7 clear all", 12'h020, 32'd0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h028; bus_wdata = 32'hC; frame_tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; frame_tick = 1'b0;
    rd_chk("R7 set wins", 12'h020, 32'h0000_000C);

    // R6 disabling stops ticks
    wr(10'd6, 32'h0000_000C);
    check("R8 irq on", {31'd0, irq}, 32'd1);
    wr(10'd7, 32'h0000_0000);
    wr(10'd10, 32'h0000_000C);
    check("R8 irq cleared", {31'd0, irq}, 32'd0);
    tick();
    rd_chk("R6 disabled tick", 12'h020, 32'd0);
    check("R6 irq stays low", {31'd0, irq}, 32'd0);

    // R10 identification, base
    for (int i = 0; i < 8; i++) rd_chk("R10 id base", 12'(12'hFE0 + i * 4), {24'd0, ids[i]});

    // R3 swapped layout
    @(negedge clk); variant = 2'd1;
    wr(10'd6, 32'h0000_0801);
    rd_chk("R3 ctrl at 6", 12'h018, 32'h0000_0801);
    check("R3 panel_on swap", {31'd0, panel_on}, 32'd1);
    wr(10'd7, 32'h0000_0008);
    rd_chk("R3 mask at 7", 12'h01C, 32'h0000_0008);
    for (int i = 0; i < 8; i++) rd_chk("R10 id swap", 12'(12'hFE0 + i * 4), {24'd0, ids[i]});

    // R10 extended ids, R11 write to id range ignored
    @(negedge clk); variant = 2'd2;
    ids[0] = 8'h11; ids[2] = 8'h24;
    wr(10'h3F8, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) rd_chk("R10 id ext", 12'(12'hFE0 + i * 4), {24'd0, ids[i]});
    rd_chk("R11 ctrl untouched", 12'h018, 32'h0000_0801);

    finish_run();
  end
endmodule